// File: doc/BRIEF.md
# Byte-Lane I/Q Slot Port

This block sits between a user I/Q mapping module and the framer of a serial radio link. It gives the user direct access, one byte at a time, to the I/Q slots of each frame. Both directions use a 32-bit word split into four byte lanes. Lane n occupies bits [8n+7:8n]. A free-running position counter walks through the words of one frame. A fixed schedule marks each byte position of the frame as either an I/Q slot or a reserved (non-I/Q) slot.

On the transmit side the block raises a per-lane ready one cycle before it reads the lanes. A byte is taken only if ready was high in the previous cycle and valid is high now. The accepted word then enters a pipeline that can be made longer by a parameter. Offered slots that the user leaves empty are filled with zero and counted for each frame. Valid bits on lanes that were not offered are dropped and set a sticky error flag.

On the receive side the block passes on each incoming frame word one cycle later. A four-bit valid mask marks which of its bytes are I/Q data.

Top module: `iq_lane_port`

## Requirements
- R1: A frame is FRAME_WORDS words. Byte position p = 4*w + n (word w, lane n) is a reserved slot when p < CTRL_BYTES and an I/Q slot otherwise. `frm_sof` is high exactly in the cycle that serves word 0.
- R2: `tx_ready[n]` is high in a cycle exactly when lane n of the word served in the next cycle is an I/Q slot.
- R3: A transmit byte in lane n is taken only when `tx_ready[n]` was high in the previous cycle and `tx_valid[n]` is high in the current cycle. The taken byte appears unchanged in lane n of `frm_tx_data`.
- R4: An offered lane without valid is output as 0x00. The number of such bytes in a frame is shown on `ufl_count` for the whole of the following frame.
- R5: A valid bit on a lane whose ready was low in the previous cycle is ignored: that output byte is 0x00. `proto_err` goes high the next cycle and stays high until reset.
- R6: While `rst_n` is low, `tx_ready`, `rx_valid`, `proto_err`, `ufl_count` and `frm_tx_live` are 0. The first served word after reset is word 0.
- R7: A served word appears on `frm_tx_data` exactly 1 + AUX_DELAY cycles after its serve cycle (AUX_DELAY in 0..15). It arrives together with its I/Q lane mask on `frm_tx_mask`, its word-0 flag on `frm_tx_sof` and `frm_tx_live` high.
- R8: `rx_valid` equals the I/Q lane mask of the word served in the previous cycle. `rx_data` carries that cycle's `frm_rx_data` bytes in valid lanes and 0x00 in all other lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_ready | output | 4 | Per-lane acceptance for the next cycle |
| tx_valid | input | 4 | Per-lane user byte valid |
| tx_data | input | 32 | User transmit word |
| frm_tx_data | output | 32 | Word to the framer, I/Q slots filled |
| frm_tx_mask | output | 4 | I/Q lane mask of the outgoing word |
| frm_tx_sof | output | 1 | Outgoing word is word 0 of a frame |
| frm_tx_live | output | 1 | Outgoing word is a real frame position |
| frm_rx_data | input | 32 | Incoming frame word for the served position |
| frm_sof | output | 1 | Current served position is word 0 |
| rx_valid | output | 4 | Per-lane I/Q valid of `rx_data` |
| rx_data | output | 32 | Received I/Q bytes |
| ufl_count | output | UFL_W | Underfilled bytes in the previous frame |
| proto_err | output | 1 | Sticky: valid seen on a lane that was not offered |

## Verification
On every cycle, the assertions check three things. Ready is quiet in reset. A stray valid raises the error flag, and the flag then never drops. The receive valid mask tracks the ready mask given two cycles earlier. The pipeline depth, the zero fill of empty and stray lanes, and the per-frame underflow totals can only be seen through the bench's scenarios. These scenarios are full fill, alternating lanes, an empty frame and valid on reserved lanes. The scoreboard compares each of them word by word against a model of the slot schedule.

// File: rtl/iq_lane_pkg.sv
package iq_lane_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  // I/Q lane mask of a frame word: byte slot 4*w+n is I/Q when not reserved
  function automatic logic [LANES-1:0] slot_mask(input int unsigned word,
                                                 input int unsigned ctrl_bytes);
    logic [LANES-1:0] m;
    for (int n = 0; n < LANES; n++) begin
      m[n] = ((word * LANES) + n) >= ctrl_bytes;
    end
    return m;
  endfunction

  function automatic int unsigned lane_count(input logic [LANES-1:0] m);
    int unsigned c;
    c = 0;
    for (int n = 0; n < LANES; n++) c += int'(m[n]);
    return c;
  endfunction

  // keep only the bytes whose lane bit is set
  function automatic logic [WORD_W-1:0] lane_keep(input logic [WORD_W-1:0] d,
                                                  input logic [LANES-1:0] m);
    logic [WORD_W-1:0] r;
    for (int n = 0; n < LANES; n++) begin
      r[n*LANE_W +: LANE_W] = m[n] ? d[n*LANE_W +: LANE_W] : '0;
    end
    return r;
  endfunction
endpackage

// File: rtl/iq_slot_sched.sv
module iq_slot_sched
  import iq_lane_pkg::*;
#(
  parameter int FRAME_WORDS = 8,
  parameter int CTRL_BYTES  = 6,
  localparam int PW = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             run_o,
  output logic             sof_o,
  output logic             last_o,
  output logic [LANES-1:0] serve_mask_o,
  output logic [LANES-1:0] ahead_mask_o
);
  localparam logic [PW-1:0] LAST_W = PW'(FRAME_WORDS - 1);

  logic          run_q;
  logic [PW-1:0] word_q;
  logic [PW-1:0] word_nxt;

  assign word_nxt = (word_q == LAST_W) ? '0 : word_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      word_q <= '0;
    end else begin
      run_q <= 1'b1;
      if (run_q) word_q <= word_nxt;
    end
  end

  assign run_o        = run_q;
  assign sof_o        = run_q && (word_q == '0);
  assign last_o       = run_q && (word_q == LAST_W);
  assign serve_mask_o = run_q ? slot_mask(int'(word_q), CTRL_BYTES) : '0;
  assign ahead_mask_o = run_q ? slot_mask(int'(word_nxt), CTRL_BYTES) : '0;

  AST_READY_QUIET_RESET: assert property (@(posedge clk)
    !rst_n |-> (ahead_mask_o == '0)); // R6

  if (FRAME_WORDS > 1) begin : g_sof_chk
    AST_SOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      sof_o |=> !sof_o); // R1
  end
endmodule

// File: rtl/iq_tx_gate.sv
module iq_tx_gate
  import iq_lane_pkg::*;
#(
  parameter int UFL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              sof_i,
  input  logic              last_i,
  input  logic [LANES-1:0]  serve_mask_i,
  input  logic [LANES-1:0]  ready_i,
  input  logic [LANES-1:0]  valid_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] word_o,
  output logic [LANES-1:0]  mask_o,
  output logic              sof_o,
  output logic              live_o,
  output logic [UFL_W-1:0]  ufl_o,
  output logic              err_o
);
  logic [LANES-1:0]  ready_q;
  logic [LANES-1:0]  take_w;
  logic [LANES-1:0]  miss_w;
  logic [LANES-1:0]  stray_w;
  logic [UFL_W-1:0]  acc_q;
  logic [UFL_W-1:0]  acc_sum_w;

  assign take_w    = ready_q & valid_i;
  assign miss_w    = run_i ? (ready_q & ~valid_i) : '0;
  assign stray_w   = run_i ? (valid_i & ~ready_q) : '0;
  assign acc_sum_w = acc_q + UFL_W'(lane_count(miss_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= '0;
      word_o  <= '0;
      mask_o  <= '0;
      sof_o   <= 1'b0;
      live_o  <= 1'b0;
      acc_q   <= '0;
      ufl_o   <= '0;
      err_o   <= 1'b0;
    end else begin
      ready_q <= ready_i;
      word_o  <= lane_keep(data_i, take_w);
      mask_o  <= serve_mask_i;
      sof_o   <= sof_i;
      live_o  <= run_i;
      if (stray_w != '0) err_o <= 1'b1;
      if (run_i) begin
        if (last_i) begin
          ufl_o <= acc_sum_w;
          acc_q <= '0;
        end else begin
          acc_q <= acc_sum_w;
        end
      end
    end
  end

  AST_STRAY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (stray_w != '0) |=> err_o); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o); // R5
endmodule

// File: rtl/iq_delay_line.sv
module iq_delay_line #(
  parameter int DEPTH = 2,
  parameter int W     = 38
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  if (DEPTH == 0) begin : g_pass
    assign dout = din;
  end else begin : g_pipe
    logic [W-1:0] stg [DEPTH];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
      end else begin
        stg[0] <= din;
        for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
      end
    end
    assign dout = stg[DEPTH-1];
  end
endmodule

// File: rtl/iq_rx_lanes.sv
module iq_rx_lanes
  import iq_lane_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  serve_mask_i,
  input  logic [WORD_W-1:0] frm_data_i,
  output logic [LANES-1:0]  valid_o,
  output logic [WORD_W-1:0] data_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= '0;
      data_o  <= '0;
    end else begin
      valid_o <= serve_mask_i;
      data_o  <= lane_keep(frm_data_i, serve_mask_i);
    end
  end
endmodule

// File: rtl/iq_lane_port.sv
module iq_lane_port
  import iq_lane_pkg::*;
#(
  parameter int FRAME_WORDS = 8,
  parameter int CTRL_BYTES  = 6,
  parameter int AUX_DELAY   = 2,
  localparam int UFL_W = $clog2(FRAME_WORDS * 4 + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [3:0]       tx_ready,
  input  logic [3:0]       tx_valid,
  input  logic [31:0]      tx_data,
  output logic [31:0]      frm_tx_data,
  output logic [3:0]       frm_tx_mask,
  output logic             frm_tx_sof,
  output logic             frm_tx_live,
  input  logic [31:0]      frm_rx_data,
  output logic             frm_sof,
  output logic [3:0]       rx_valid,
  output logic [31:0]      rx_data,
  output logic [UFL_W-1:0] ufl_count,
  output logic             proto_err
);
  localparam int PKT_W = WORD_W + LANES + 2;

  logic             run_w, sof_w, last_w;
  logic [LANES-1:0] serve_mask_w;
  logic [WORD_W-1:0] s0_word;
  logic [LANES-1:0]  s0_mask;
  logic              s0_sof, s0_live;
  logic [PKT_W-1:0]  pkt_in, pkt_out;

  iq_slot_sched #(.FRAME_WORDS(FRAME_WORDS), .CTRL_BYTES(CTRL_BYTES)) sched_i (
    .clk(clk), .rst_n(rst_n), .run_o(run_w), .sof_o(sof_w), .last_o(last_w),
    .serve_mask_o(serve_mask_w), .ahead_mask_o(tx_ready)
  );

  iq_tx_gate #(.UFL_W(UFL_W)) gate_i (
    .clk(clk), .rst_n(rst_n), .run_i(run_w), .sof_i(sof_w), .last_i(last_w),
    .serve_mask_i(serve_mask_w), .ready_i(tx_ready), .valid_i(tx_valid),
    .data_i(tx_data), .word_o(s0_word), .mask_o(s0_mask), .sof_o(s0_sof),
    .live_o(s0_live), .ufl_o(ufl_count), .err_o(proto_err)
  );

  assign pkt_in = {s0_live, s0_sof, s0_mask, s0_word};

  iq_delay_line #(.DEPTH(AUX_DELAY), .W(PKT_W)) aux_i (
    .clk(clk), .rst_n(rst_n), .din(pkt_in), .dout(pkt_out)
  );

  assign {frm_tx_live, frm_tx_sof, frm_tx_mask, frm_tx_data} = pkt_out;

  iq_rx_lanes rx_i (
    .clk(clk), .rst_n(rst_n), .serve_mask_i(serve_mask_w),
    .frm_data_i(frm_rx_data), .valid_o(rx_valid), .data_o(rx_data)
  );

  assign frm_sof = sof_w;

  AST_RX_TRACKS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run_w, 2) |-> (rx_valid == $past(tx_ready, 2))); // R8
endmodule

// File: tb/iq_lane_port_tb.sv
`timescale 1ns/1ps
module iq_lane_port_tb_top;
  localparam int FW   = 8;
  localparam int CTRL = 6;
  localparam int AUX  = 2;
  localparam int UW   = $clog2(FW * 4 + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]  tx_ready, tx_valid = '0, frm_tx_mask, rx_valid;
  logic [31:0] tx_data = '0, frm_tx_data, frm_rx_data = '0, rx_data;
  logic        frm_tx_sof, frm_tx_live, frm_sof, proto_err;
  logic [UW-1:0] ufl_count;

  always #5 clk = ~clk;

  iq_lane_port #(.FRAME_WORDS(FW), .CTRL_BYTES(CTRL), .AUX_DELAY(AUX)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .frm_tx_data(frm_tx_data), .frm_tx_mask(frm_tx_mask),
    .frm_tx_sof(frm_tx_sof), .frm_tx_live(frm_tx_live), .frm_rx_data(frm_rx_data),
    .frm_sof(frm_sof), .rx_valid(rx_valid), .rx_data(rx_data),
    .ufl_count(ufl_count), .proto_err(proto_err)
  );

  typedef struct {
    logic [31:0] data;
    logic [3:0]  mask;
    logic        sof;
    int          cyc;
  } exp_t;

  exp_t txq[$];
  exp_t rxq[$];
  int checks = 0, failures = 0, cyc = 0;
  int pos = 0;
  bit first = 1'b1, err_model = 1'b0, have_ufl = 1'b0;
  int ufl_acc = 0, ufl_prev = 0;
  logic [31:0] lfsr = 32'h1D2C_3B4A;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reserved when byte index is below CTRL
  function automatic logic [3:0] iq_of(input int w);
    logic [3:0] m;
    for (int n = 0; n < 4; n++) m[n] = !((w * 4 + n) < CTRL);
    return m;
  endfunction

  function automatic logic [31:0] pick(input logic [31:0] d, input logic [3:0] m);
    logic [31:0] r;
    r = 32'h0;
    for (int n = 0; n < 4; n++) if (m[n]) r[n*8 +: 8] = d[n*8 +: 8];
    return r;
  endfunction

  function automatic int ones(input logic [3:0] m);
    return int'(m[0]) + int'(m[1]) + int'(m[2]) + int'(m[3]);
  endfunction

  // called at a negedge in the cycle serving position pos
  task automatic serve(input int mode);
    logic [3:0] pr, v;
    logic [31:0] rxd;
    exp_t e;
    int nxt;
    nxt = (pos == FW - 1) ? 0 : pos + 1;
    pr  = first ? 4'h0 : iq_of(pos);
    check(tx_ready == iq_of(nxt), "R2 tx_ready", {28'h0, tx_ready}, {28'h0, iq_of(nxt)});
    check(frm_sof == (pos == 0), "R1 frm_sof", {31'h0, frm_sof}, {31'h0, pos == 0});
    check(proto_err == err_model, "R5 proto_err", {31'h0, proto_err}, {31'h0, err_model});
    if (pos == 0 && have_ufl)
      check(ufl_count == UW'(ufl_prev), "R4 ufl_count", 32'(ufl_count), 32'(ufl_prev));
    case (mode)
      0: v = pr;
      1: v = pr & ((pos % 2 == 0) ? 4'b1010 : 4'b0101);
      2: v = 4'h0;
      default: v = 4'hF;
    endcase
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    rxd  = ~lfsr ^ 32'h5A5A_0F0F;
    tx_valid    = v;
    tx_data     = lfsr;
    frm_rx_data = rxd;
    e.data = pick(lfsr, pr & v); e.mask = iq_of(pos); e.sof = (pos == 0); e.cyc = cyc;
    txq.push_back(e);
    if (iq_of(pos) != 4'h0) begin
      e.data = pick(rxd, iq_of(pos)); e.mask = iq_of(pos); e.sof = 1'b0; e.cyc = cyc;
      rxq.push_back(e);
    end
    ufl_acc += ones(pr & ~v);
    if (pos == FW - 1) begin
      ufl_prev = ufl_acc; ufl_acc = 0; have_ufl = 1'b1;
    end
    if ((v & ~pr) != 4'h0) err_model = 1'b1;
    pos = nxt;
    first = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && frm_tx_live) begin
      if (txq.size() == 0) begin
        check(1'b0, "R7 unexpected tx word", frm_tx_data, 32'h0);
      end else begin
        exp_t t;
        t = txq.pop_front();
        check(frm_tx_data == t.data, "R3/R4/R5 frm_tx_data", frm_tx_data, t.data);
        check(frm_tx_mask == t.mask, "R1 frm_tx_mask", {28'h0, frm_tx_mask}, {28'h0, t.mask});
        check(frm_tx_sof == t.sof, "R7 frm_tx_sof", {31'h0, frm_tx_sof}, {31'h0, t.sof});
        check(cyc - t.cyc == 1 + AUX, "R7 latency", 32'(cyc - t.cyc), 32'(1 + AUX));
      end
    end
    if (rst_n && rx_valid != 4'h0) begin
      if (rxq.size() == 0) begin
        check(1'b0, "R8 unexpected rx word", rx_data, 32'h0);
      end else begin
        exp_t r;
        r = rxq.pop_front();
        check(rx_valid == r.mask, "R8 rx_valid", {28'h0, rx_valid}, {28'h0, r.mask});
        check(rx_data == r.data, "R8 rx_data", rx_data, r.data);
        check(cyc - r.cyc == 1, "R8 latency", 32'(cyc - r.cyc), 32'd1);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(tx_ready == 4'h0, "R6 reset tx_ready", {28'h0, tx_ready}, 32'h0);
    check(rx_valid == 4'h0, "R6 reset rx_valid", {28'h0, rx_valid}, 32'h0);
    check(proto_err == 1'b0, "R6 reset proto_err", {31'h0, proto_err}, 32'h0);
    check(ufl_count == '0, "R6 reset ufl_count", 32'(ufl_count), 32'h0);
    check(frm_tx_live == 1'b0, "R6 reset frm_tx_live", {31'h0, frm_tx_live}, 32'h0);
    rst_n = 1'b1;
    @(posedge clk);
    // frames: full fill, alternating lanes, empty, full, stray valid, full
    for (int f = 0; f < 6; f++) begin
      for (int w = 0; w < FW; w++) begin
        @(negedge clk);
        case (f)
          1: serve(1);
          2: serve(2);
          4: serve(3);
          default: serve(0);
        endcase
      end
    end
    for (int k = 0; k < AUX + 4; k++) begin
      @(negedge clk);
      serve(0);
    end
    check(proto_err == 1'b1, "R5 sticky at end", {31'h0, proto_err}, 32'h1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule